// File: doc/BRIEF.md
# Dual-Channel Tick-Count PWM Generator

This block drives two independent pulse-width outputs. The waveform of each channel is set by two tick counts: how long the output stays high and how long it stays low. The period is therefore the sum of the two phases, not a period register paired with a compare value. A small word-wide register port holds one data word per channel and one shared control word. The control word gives each channel an enable, a constant-level mode, an output invert, a count-clock gate, a selector over four input tick enables, and a 7-bit divider. The input tick enables and the bus protocol belong to the surrounding system; the port here is a plain write strobe, an address and data, with combinational read data.

Each channel's count clock is built in three stages. First a mux picks one of the four `src_tick` enables. A divider then passes one pulse in every `div+1` selected pulses. Last, the gate stops or passes the divided tick. The divided tick advances a state machine with three states: PH_IDLE (channel off, counter cleared), PH_HIGH (output high phase) and PH_LOW (output low phase). The transitions are as follows. IDLE->HIGH takes one clock after the enable is seen and loads the shadow counts. HIGH->LOW happens when the phase counter reaches the high terminal. LOW->HIGH happens at the low terminal and reloads the shadow counts from the data register. Any state returns to IDLE on the first clock with the enable clear.

Top module: `dual_tick_pwm`

## Requirements
- R1: The data word of channel n sits at address n (n = 0, 1). Bits [15:0] hold the high count and bits [31:16] hold the low count. Reading the address returns the stored word. Address 3 reads as zero. Every register reads zero after reset.
- R2: With constant mode clear, an enabled channel enters PH_HIGH one clock after the enable is registered. Its output is high for high+1 divided ticks, then low for low+1 divided ticks, and the cycle repeats.
- R3: The control word at address 2 has a 16-bit slice per channel, with channel n at bit 16n. The slice holds enable at bit 0, constant at bit 1, invert at bit 2, gate at bit 3, source select at bits [5:4] and divider at bits [12:6]. The other bits are not stored and read as zero.
- R4: With constant mode set, a shadow high count of zero holds the output low. Otherwise, a shadow low count of zero holds it high, with no change at phase boundaries. When both counts are nonzero, the phases last exactly high and low divided ticks.
- R5: Clearing the enable forces the output to its idle level on the clock edge that stores the write, even in the middle of a phase.
- R6: A disabled channel outputs 0, or 1 when its invert bit is set. Its phase counter and divider counter are held at zero. An enabled channel's level is also flipped by the invert bit.
- R7: Counts written while a channel runs take effect only at the next LOW->HIGH boundary.
- R8: The control word reads back exactly as written, apart from the bits that R3 leaves unstored.
- R9: The source select picks `src_tick[sel]`. The divided tick occurs on every (div+1)-th selected enable. While the gate is clear, no divided tick occurs and the divider count is held.
- R10: The two channels share only the control word. Reprogramming one channel never changes the other channel's output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Four candidate count-clock enables |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | 2 | One PWM output per channel |

## Verification
The four tick sources carry different patterns: one always set, one every other clock, one every third clock, and one pseudo-random. Selecting each of these separates a correct source mux and divider from one that ignores the selector or miscounts the ratio. The count pairs include small unequal values, a zero high count and a zero low count in both modes, and a mid-run rewrite. Together these separate the plus-one rule from the exact-count rule and show when the shadow copy reloads. A behavioural model is compared against both outputs on every clock. Because one channel keeps running while the other is gated, disabled and reprogrammed, any coupling between the channels also shows up.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    localparam int DIV_W       = 7;
    localparam int SEL_W       = 2;
    localparam int CTRL_STRIDE = 16;

    // Field order: MSB first, so en lands at bit 0 of the slice.
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
        logic             gate;
        logic             inv;
        logic             cst;
        logic             en;
    } chan_ctrl_t;

    localparam int CTRL_BITS = $bits(chan_ctrl_t);

endpackage

// File: rtl/dtpwm_regs.sv
module dtpwm_regs
    import dtpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int AW     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [AW-1:0]                 addr,
    input  logic [2*CNT_W-1:0]            wdata,
    output logic [2*CNT_W-1:0]            rdata,
    output logic [NUM_CH-1:0][CNT_W-1:0]  hi_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]  lo_o,
    output chan_ctrl_t [NUM_CH-1:0]       ctrl_o
);
    localparam int DW        = 2 * CNT_W;
    localparam int CTRL_ADDR = NUM_CH;

    logic [NUM_CH-1:0][CNT_W-1:0] hi_q;
    logic [NUM_CH-1:0][CNT_W-1:0] lo_q;
    chan_ctrl_t [NUM_CH-1:0]      ctrl_q;
    logic [DW-1:0]                ctrl_word;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_q[c]   <= '0;
                lo_q[c]   <= '0;
                ctrl_q[c] <= '0;
            end else if (wr) begin
                if (int'(addr) == c) begin
                    hi_q[c] <= wdata[CNT_W-1:0];
                    lo_q[c] <= wdata[DW-1:CNT_W];
                end
                if (int'(addr) == CTRL_ADDR) begin
                    ctrl_q[c] <= chan_ctrl_t'(wdata[c*CTRL_STRIDE +: CTRL_BITS]);
                end
            end
        end
    end

    always_comb begin
        ctrl_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            ctrl_word[c*CTRL_STRIDE +: CTRL_BITS] = ctrl_q[c];
        end
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(addr) == c) rdata = {lo_q[c], hi_q[c]};
        end
        if (int'(addr) == CTRL_ADDR) rdata = ctrl_word;
    end

    assign hi_o   = hi_q;
    assign lo_o   = lo_q;
    assign ctrl_o = ctrl_q;

    // R8: a control write is stored exactly in the slice bits.
    assert_ctrl_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && int'(addr) == CTRL_ADDR) |=>
            (ctrl_q[0] == chan_ctrl_t'($past(wdata[CTRL_BITS-1:0]))));

endmodule

// File: rtl/dtpwm_tick.sv
module dtpwm_tick
    import dtpwm_pkg::*;
#(
    parameter int SRC_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             gate,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div,
    input  logic [SRC_N-1:0] src_tick,
    output logic             tick_o
);
    logic [DIV_W-1:0] dcnt;
    logic             picked;
    logic             at_end;

    assign picked = src_tick[sel];
    assign at_end = (dcnt >= div);
    assign tick_o = run && gate && picked && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt <= '0;
        end else if (!run) begin
            dcnt <= '0;
        end else if (gate && picked) begin
            dcnt <= at_end ? '0 : dcnt + 1'b1;
        end
    end

    // R9: after a divided tick the next one needs div+1 more enables.
    assert_tick_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (!tick_o || div == '0));

    // R6: a stopped divider sits at zero.
    assert_div_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (dcnt == '0));

endmodule

// File: rtl/dtpwm_chan.sv
module dtpwm_chan
    import dtpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             cst,
    input  logic             inv,
    input  logic [CNT_W-1:0] hi,
    input  logic [CNT_W-1:0] lo,
    output logic             pwm_o
);
    phase_e           ph, ph_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] sh_hi, sh_lo;
    logic             load;
    logic [CNT_W-1:0] term_hi, term_lo;
    logic             lvl;

    function automatic logic [CNT_W-1:0] term_of(input logic [CNT_W-1:0] v,
                                                  input logic exact);
        if (!exact)       return v;
        else if (v == '0) return '0;
        else              return v - 1'b1;
    endfunction

    assign term_hi = term_of(sh_hi, cst);
    assign term_lo = term_of(sh_lo, cst);

    // Next-state process.
    always_comb begin
        ph_n  = ph;
        cnt_n = cnt;
        load  = 1'b0;
        unique case (ph)
            PH_IDLE: begin
                ph_n  = PH_HIGH;
                cnt_n = '0;
                load  = 1'b1;
            end
            PH_HIGH: begin
                if (tick) begin
                    if (cnt >= term_hi) begin
                        ph_n  = PH_LOW;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            PH_LOW: begin
                if (tick) begin
                    if (cnt >= term_lo) begin
                        ph_n  = PH_HIGH;
                        cnt_n = '0;
                        load  = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            default: begin
                ph_n  = PH_IDLE;
                cnt_n = '0;
            end
        endcase
        if (!en) begin
            ph_n  = PH_IDLE;
            cnt_n = '0;
            load  = 1'b0;
        end
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            sh_hi <= '0;
            sh_lo <= '0;
        end else begin
            ph  <= ph_n;
            cnt <= cnt_n;
            if (load) begin
                sh_hi <= hi;
                sh_lo <= lo;
            end
        end
    end

    // Output process.
    always_comb begin
        unique case (ph)
            PH_HIGH: lvl = 1'b1;
            PH_LOW:  lvl = 1'b0;
            default: lvl = 1'b0;
        endcase
        if (cst && sh_hi == '0)      lvl = 1'b0;
        else if (cst && sh_lo == '0) lvl = 1'b1;
        pwm_o = (en && ph != PH_IDLE) ? (lvl ^ inv) : inv;
    end

    // R6: a disabled channel rests in PH_IDLE with a cleared counter.
    assert_off_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ph == PH_IDLE && cnt == '0));

    // R2: the phase counter never passes the programmed count.
    assert_high_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_HIGH && !cst) |-> (cnt <= sh_hi));

    assert_low_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_LOW && !cst) |-> (cnt <= sh_lo));

    // R4: a zero low count in constant mode never lets the output move.
    assert_const_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cst && ph != PH_IDLE && sh_hi != '0 && sh_lo == '0 &&
         $past(en && cst && ph != PH_IDLE && sh_hi != '0 && sh_lo == '0) &&
         $stable(inv)) |-> $stable(pwm_o));

endmodule

// File: rtl/dual_tick_pwm.sv
module dual_tick_pwm
    import dtpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int SRC_N  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_N-1:0]     src_tick,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [2*CNT_W-1:0]   reg_wdata,
    output logic [2*CNT_W-1:0]   reg_rdata,
    output logic [NUM_CH-1:0]    pwm_out
);
    logic [NUM_CH-1:0][CNT_W-1:0] hi_w;
    logic [NUM_CH-1:0][CNT_W-1:0] lo_w;
    chan_ctrl_t [NUM_CH-1:0]      ctrl_w;
    logic [NUM_CH-1:0]            tick_w;

    dtpwm_regs #(
        .CNT_W  (CNT_W),
        .NUM_CH (NUM_CH),
        .AW     (2)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .hi_o   (hi_w),
        .lo_o   (lo_w),
        .ctrl_o (ctrl_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dtpwm_tick #(
            .SRC_N (SRC_N)
        ) u_tick (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (ctrl_w[c].en),
            .gate     (ctrl_w[c].gate),
            .sel      (ctrl_w[c].sel),
            .div      (ctrl_w[c].div),
            .src_tick (src_tick),
            .tick_o   (tick_w[c])
        );

        dtpwm_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_w[c]),
            .en    (ctrl_w[c].en),
            .cst   (ctrl_w[c].cst),
            .inv   (ctrl_w[c].inv),
            .hi    (hi_w[c]),
            .lo    (lo_w[c]),
            .pwm_o (pwm_out[c])
        );
    end

    // R5: an enable cleared by a write idles the output on that same edge.
    assert_stop_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && !reg_wdata[0]) |=>
            (pwm_out[0] == reg_rdata[2] || reg_addr != 2'd2 ||
             pwm_out[0] == $past(reg_wdata[2])));

endmodule

// File: tb/dual_tick_pwm_bench.sv
module dual_tick_pwm_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  b_src = 4'b0;
    logic        b_wr = 1'b0;
    logic [1:0]  b_addr = 2'd0;
    logic [31:0] b_wdata = 32'd0;
    logic [31:0] rdata;
    logic [1:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit cmp_on = 0;
    string tag = "R6";
    int cyc = 0;
    logic [7:0] lfsr = 8'hA5;

    always #10 clk = ~clk;

    dual_tick_pwm u_dual_tick_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_tick  (b_src),
        .reg_wr    (b_wr),
        .reg_addr  (b_addr),
        .reg_wdata (b_wdata),
        .reg_rdata (rdata),
        .pwm_out   (pwm_out)
    );

    // Behavioural reference model.
    int m_hi[2], m_lo[2], m_div[2], m_sel[2], m_dcnt[2];
    int m_ph[2], m_cnt[2], m_shh[2], m_shl[2];
    bit m_en[2], m_cst[2], m_inv[2], m_gate[2];

    function automatic int mterm(int v, bit exact);
        if (!exact) return v;
        return (v == 0) ? 0 : v - 1;
    endfunction

    function automatic bit m_out(int c);
        bit l;
        l = (m_ph[c] == 1);
        if (m_cst[c] && m_shh[c] == 0) l = 0;
        else if (m_cst[c] && m_shl[c] == 0) l = 1;
        return (m_en[c] && m_ph[c] != 0) ? (l ^ m_inv[c]) : m_inv[c];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_hi[c] = 0; m_lo[c] = 0; m_div[c] = 0; m_sel[c] = 0;
                m_dcnt[c] = 0; m_ph[c] = 0; m_cnt[c] = 0; m_shh[c] = 0;
                m_shl[c] = 0; m_en[c] = 0; m_cst[c] = 0; m_inv[c] = 0;
                m_gate[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit pick, tk;
                pick = b_src[m_sel[c]];
                tk = m_en[c] && m_gate[c] && pick && (m_dcnt[c] >= m_div[c]);
                if (!m_en[c]) m_dcnt[c] = 0;
                else if (m_gate[c] && pick) m_dcnt[c] = (m_dcnt[c] >= m_div[c]) ? 0 : m_dcnt[c] + 1;
                if (!m_en[c]) begin
                    m_ph[c] = 0; m_cnt[c] = 0;
                end else if (m_ph[c] == 0) begin
                    m_ph[c] = 1; m_cnt[c] = 0; m_shh[c] = m_hi[c]; m_shl[c] = m_lo[c];
                end else if (tk && m_ph[c] == 1) begin
                    if (m_cnt[c] >= mterm(m_shh[c], m_cst[c])) begin m_ph[c] = 2; m_cnt[c] = 0; end
                    else m_cnt[c]++;
                end else if (tk && m_ph[c] == 2) begin
                    if (m_cnt[c] >= mterm(m_shl[c], m_cst[c])) begin
                        m_ph[c] = 1; m_cnt[c] = 0; m_shh[c] = m_hi[c]; m_shl[c] = m_lo[c];
                    end else m_cnt[c]++;
                end
            end
            if (b_wr) begin
                if (b_addr < 2) begin
                    m_hi[b_addr] = b_wdata[15:0];
                    m_lo[b_addr] = b_wdata[31:16];
                end else if (b_addr == 2) begin
                    for (int c = 0; c < 2; c++) begin
                        m_en[c]   = b_wdata[16*c];
                        m_cst[c]  = b_wdata[16*c+1];
                        m_inv[c]  = b_wdata[16*c+2];
                        m_gate[c] = b_wdata[16*c+3];
                        m_sel[c]  = b_wdata[16*c+4 +: 2];
                        m_div[c]  = b_wdata[16*c+6 +: 7];
                    end
                end
            end
        end
    end

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Tick source patterns, driven away from the active edge.
    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        b_src = {lfsr[0], (cyc % 3) == 0, cyc[0], 1'b1};
    end

    // Per-cycle output comparison.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            for (int c = 0; c < 2; c++)
                check(pwm_out[c] == m_out(c), tag, pwm_out[c], m_out(c));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        b_wr = 1'b1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, string req);
        b_addr = a;
        #1;
        check(rdata == exp, req, rdata, exp);
    endtask

    function automatic logic [15:0] slice(bit en, bit cst, bit inv, bit gate,
                                          int sel, int div);
        return {3'b0, 7'(div), 2'(sel), gate, inv, cst, en};
    endfunction

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(2'd0, 32'd0, "R1");
        rd_chk(2'd1, 32'd0, "R1");
        rd_chk(2'd2, 32'd0, "R8");
        check(pwm_out == 2'b00, "R6", pwm_out, 0);
        cmp_on = 1;

        tag = "R6";
        wr(2'd2, {16'd0, slice(0, 0, 1, 1, 0, 0)});
        check(pwm_out[0] == 1'b1, "R6", pwm_out[0], 1);
        run(10);

        tag = "R2";
        wr(2'd0, {16'd3, 16'd2});
        wr(2'd1, {16'd1, 16'd4});
        wr(2'd2, {slice(1, 0, 0, 1, 1, 0), slice(1, 0, 0, 1, 0, 0)});
        run(120);
        rd_chk(2'd0, {16'd3, 16'd2}, "R1");
        rd_chk(2'd3, 32'd0, "R1");
        rd_chk(2'd2, {slice(1, 0, 0, 1, 1, 0), slice(1, 0, 0, 1, 0, 0)}, "R8");

        tag = "R7";
        run(3);
        wr(2'd0, {16'd1, 16'd5});
        run(100);

        tag = "R9";
        wr(2'd2, {slice(1, 0, 0, 1, 1, 0), slice(1, 0, 1, 1, 3, 2)});
        run(200);
        wr(2'd2, {slice(1, 0, 0, 1, 2, 1), slice(1, 0, 0, 1, 2, 3)});
        run(150);
        wr(2'd2, {slice(1, 0, 0, 1, 2, 1), slice(1, 0, 0, 0, 2, 3)});
        run(50);

        tag = "R4";
        wr(2'd0, {16'd5, 16'd0});
        wr(2'd2, {slice(1, 0, 0, 1, 1, 0), slice(1, 1, 0, 1, 0, 0)});
        run(60);
        wr(2'd0, {16'd0, 16'd3});
        run(60);
        wr(2'd0, {16'd3, 16'd2});
        run(60);

        tag = "R5";
        wr(2'd2, {slice(1, 0, 0, 1, 1, 0), slice(1, 0, 1, 1, 0, 0)});
        run(7);
        wr(2'd2, {slice(1, 0, 0, 1, 1, 0), slice(0, 0, 1, 1, 0, 0)});
        check(pwm_out[0] == 1'b1, "R5", pwm_out[0], 1);
        run(20);

        tag = "R10";
        wr(2'd0, {16'd2, 16'd6});
        wr(2'd2, {slice(1, 0, 0, 1, 1, 0), slice(1, 0, 0, 1, 3, 1)});
        run(100);

        tag = "R3";
        wr(2'd2, 32'hFFFF_FFFF);
        rd_chk(2'd2, 32'h1FFF_1FFF, "R3");
        run(40);
        wr(2'd2, 32'h0000_0000);
        rd_chk(2'd2, 32'h0000_0000, "R3");
        check(pwm_out == 2'b00, "R6", pwm_out, 0);
        run(5);

        cmp_on = 0;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule